// File: doc/BRIEF.md
# Edge-Triggered Cartridge Bank Controller

This block switches memory banks for an 8-bit console cartridge. It watches CPU writes in the upper half of the CPU address space and keeps a single control register there. The register holds one switchable 16 KiB program bank and one switchable 8 KiB graphics bank. The block turns CPU addresses into program ROM addresses and pattern-bus addresses into graphics ROM addresses.

A bank number is not taken from every write. The program bank loads only when its control bit goes from 0 to 1 between the stored value and the new value, and the same holds for the graphics bank. The control bit for the program bank is bit 7 and the control bit for the graphics bank is bit 6. The written byte is first ANDed with the program ROM byte at the write address, because the ROM drives the data bus during the write. The stored copy of the previous value is refreshed on every write the block accepts.

The upper 16 KiB CPU window always shows the last program bank. Software therefore has a fixed home for its reset and interrupt code.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with `cpu_addr[15]` = 0 changes no state: the later bank loads and the translated addresses behave as if that write had not happened.
- R2: The effective value of a write is `cpu_wdata & prg_rom_rdata`. Every load and edge decision uses the effective value, so a ROM bit that is 0 blocks the matching data bit.
- R3: When `cpu_addr[15:14]` = 2'b11, `prg_rom_addr` = {PRG_LAST, `cpu_addr[13:0]`}, with PRG_LAST = 7 by default, whatever the program bank holds.
- R4: On a write in 0x8000–0xFFFF, if bit 7 of the effective value is 1 and bit 7 of the stored previous value is 0, the program bank loads effective bits [2:0]. Otherwise the program bank keeps its value.
- R5: On a write in 0x8000–0xFFFF, if bit 6 of the effective value is 1 and bit 6 of the stored previous value is 0, the graphics bank loads effective bits [3:0]. Otherwise the graphics bank keeps its value.
- R6: Every write in 0x8000–0xFFFF stores the full effective value as the new previous value, whether or not a bank loaded.
- R7: A single write in which bits 7 and 6 both rise loads both banks from the same data.
- R8: While `rst_n` is low, the program bank, the graphics bank and the stored previous value are all 0.
- R9: When `cpu_addr[15:14]` = 2'b10, `prg_rom_addr` = {program bank, `cpu_addr[13:0]`}. `chr_rom_addr` = {graphics bank, `ppu_addr[12:0]`}. Both are combinational from the current register values, and register changes land on the clock edge that samples `cpu_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising clock edge |
| prg_rom_rdata | input | 8 | Program ROM byte at the current address, used for conflict masking |
| ppu_addr | input | 13 | Pattern-bus address |
| prg_rom_addr | output | 17 | Program ROM byte address |
| chr_rom_addr | output | 17 | Graphics ROM byte address |

## Verification
The bench repeats a write while the program control bit stays high. A design that loads on level rather than on an edge would move the bank there. It then clears the bit and sets it again, which must reload. A decoder that forgets the previous value would miss that reload.

A write below 0x8000 is placed between two upper writes. If the low write cleared the stored value, the next upper write would wrongly reload. The conflict cases drive ROM bytes that clear the control bit or some data bits. An unmasked design would load the wrong bank, or load when it should not.

Both control bits are raised in one write to catch a design that only serves one load per write. A reset in the middle of the run must return both banks to 0, and the upper window must stay on the last bank throughout.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   parameter int unsigned CBC_DW = 8;
   typedef logic [CBC_DW-1:0] cbc_byte_t;
   typedef struct packed {
      logic      hit;
      cbc_byte_t value;
   } cbc_wr_t;
endpackage

// File: rtl/cbc_write_decode.sv
module cbc_write_decode
   import cbc_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter bit          CONFLICT_EN = 1'b1
) (
   input  logic [AW-1:0] cpu_addr,
   input  cbc_byte_t     cpu_wdata,
   input  logic          cpu_we,
   input  cbc_byte_t     rom_rdata,
   output cbc_wr_t       wr
);
   localparam int unsigned TOP_BIT = AW - 1;

   cbc_byte_t masked;

   generate
      if (CONFLICT_EN) begin : g_conflict
         always_comb masked = cpu_wdata & rom_rdata;
      end else begin : g_clean
         logic unused_rom;
         always_comb masked = cpu_wdata;
         assign unused_rom = ^rom_rdata;
      end
   endgenerate

   always_comb begin
      wr.hit   = cpu_we & cpu_addr[TOP_BIT];
      wr.value = masked;
   end
endmodule

// File: rtl/cbc_edge_latch.sv
module cbc_edge_latch
   import cbc_pkg::*;
#(
   parameter int unsigned PRG_BW   = 3,
   parameter int unsigned CHR_BW   = 4,
   parameter int unsigned PRG_CBIT = 7,
   parameter int unsigned CHR_CBIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cbc_wr_t           wr,
   output logic [PRG_BW-1:0] prg_bank,
   output logic [CHR_BW-1:0] chr_bank
);
   generate
      if (PRG_CBIT >= CBC_DW || CHR_CBIT >= CBC_DW || PRG_CBIT == CHR_CBIT) begin : g_bad_bits
         $error("cbc_edge_latch: control bit positions invalid");
      end
      if (PRG_BW > CBC_DW || CHR_BW > CBC_DW) begin : g_bad_widths
         $error("cbc_edge_latch: bank width exceeds data width");
      end
   endgenerate

   cbc_byte_t prev_q;
   logic      prg_rise, chr_rise;

   always_comb begin
      prg_rise = wr.hit & wr.value[PRG_CBIT] & ~prev_q[PRG_CBIT];
      chr_rise = wr.hit & wr.value[CHR_CBIT] & ~prev_q[CHR_CBIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         prg_bank <= '0;
         chr_bank <= '0;
      end else begin
         if (wr.hit)   prev_q   <= wr.value;
         if (prg_rise) prg_bank <= wr.value[PRG_BW-1:0];
         if (chr_rise) chr_bank <= wr.value[CHR_BW-1:0];
      end
   end

   // R6
   prev_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr.hit |=> prev_q == $past(wr.value));
   // R4
   prg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.hit && wr.value[PRG_CBIT] && !prev_q[PRG_CBIT]) |=> prg_bank == $past(wr.value[PRG_BW-1:0]));
   // R4
   prg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr.hit || !wr.value[PRG_CBIT] || prev_q[PRG_CBIT]) |=> $stable(prg_bank));
   // R5
   chr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.hit && wr.value[CHR_CBIT] && !prev_q[CHR_CBIT]) |=> chr_bank == $past(wr.value[CHR_BW-1:0]));
   // R5
   chr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr.hit || !wr.value[CHR_CBIT] || prev_q[CHR_CBIT]) |=> $stable(chr_bank));
   // R1
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr.hit |=> $stable(prev_q));
endmodule

// File: rtl/cbc_addr_xlate.sv
module cbc_addr_xlate #(
   parameter int unsigned AW       = 16,
   parameter int unsigned PRG_BW   = 3,
   parameter int unsigned CHR_BW   = 4,
   parameter int unsigned PRG_OW   = 14,
   parameter int unsigned CHR_OW   = 13,
   parameter int unsigned PRG_LAST = 7
) (
   input  logic [AW-1:0]            cpu_addr,
   input  logic [CHR_OW-1:0]        ppu_addr,
   input  logic [PRG_BW-1:0]        prg_bank,
   input  logic [CHR_BW-1:0]        chr_bank,
   output logic [PRG_BW+PRG_OW-1:0] prg_rom_addr,
   output logic [CHR_BW+CHR_OW-1:0] chr_rom_addr
);
   localparam logic [PRG_BW-1:0] LAST_IDX = PRG_BW'(PRG_LAST);

   generate
      if (PRG_OW + 2 != AW) begin : g_bad_window
         $error("cbc_addr_xlate: program window must be a quarter of the CPU space");
      end
      if (PRG_LAST >= (1 << PRG_BW)) begin : g_bad_last
         $error("cbc_addr_xlate: last bank index does not fit");
      end
   endgenerate

   logic              upper_win;
   logic [PRG_BW-1:0] sel_bank;
   logic              unused_low;

   assign unused_low = ^cpu_addr[AW-2:PRG_OW] ^ cpu_addr[AW-1];

   always_comb begin
      upper_win    = cpu_addr[AW-1] & cpu_addr[AW-2];
      sel_bank     = upper_win ? LAST_IDX : prg_bank;
      prg_rom_addr = {sel_bank, cpu_addr[PRG_OW-1:0]};
      chr_rom_addr = {chr_bank, ppu_addr};
   end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
   import cbc_pkg::*;
#(
   parameter int unsigned PRG_BW      = 3,
   parameter int unsigned CHR_BW      = 4,
   parameter int unsigned PRG_LAST    = (1 << PRG_BW) - 1,
   parameter bit          CONFLICT_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] cpu_addr,
   input  logic [7:0]  cpu_wdata,
   input  logic        cpu_we,
   input  logic [7:0]  prg_rom_rdata,
   input  logic [12:0] ppu_addr,
   output logic [PRG_BW+13:0] prg_rom_addr,
   output logic [CHR_BW+12:0] chr_rom_addr
);
   localparam int unsigned AW     = 16;
   localparam int unsigned PRG_OW = 14;
   localparam int unsigned CHR_OW = 13;

   cbc_wr_t           wr;
   logic [PRG_BW-1:0] prg_bank;
   logic [CHR_BW-1:0] chr_bank;

   cbc_write_decode #(.AW(AW), .CONFLICT_EN(CONFLICT_EN)) u_dec (
      .cpu_addr (cpu_addr),
      .cpu_wdata(cpu_wdata),
      .cpu_we   (cpu_we),
      .rom_rdata(prg_rom_rdata),
      .wr       (wr)
   );

   cbc_edge_latch #(.PRG_BW(PRG_BW), .CHR_BW(CHR_BW), .PRG_CBIT(7), .CHR_CBIT(6)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .prg_bank(prg_bank),
      .chr_bank(chr_bank)
   );

   cbc_addr_xlate #(.AW(AW), .PRG_BW(PRG_BW), .CHR_BW(CHR_BW), .PRG_OW(PRG_OW),
                    .CHR_OW(CHR_OW), .PRG_LAST(PRG_LAST)) u_xlate (
      .cpu_addr    (cpu_addr),
      .ppu_addr    (ppu_addr),
      .prg_bank    (prg_bank),
      .chr_bank    (chr_bank),
      .prg_rom_addr(prg_rom_addr),
      .chr_rom_addr(chr_rom_addr)
   );

   // R2
   conflict_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.value & ~(cpu_wdata & prg_rom_rdata)) == '0);
   // R3
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b11) |-> (prg_rom_addr[PRG_BW+13:14] == PRG_BW'(PRG_LAST)));
   // R1
   low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !cpu_addr[15]) |=> ($stable(prg_bank) && $stable(chr_bank)));
   // R9
   chr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_rom_addr[12:0] == ppu_addr);
endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_we = 1'b0;
   logic [7:0]  prg_rom_rdata = 8'hFF;
   logic [12:0] ppu_addr = '0;
   logic [16:0] prg_rom_addr;
   logic [16:0] chr_rom_addr;

   cart_bank_ctrl uut (.*);

   always #2 clk = ~clk;

   typedef struct {
      logic [16:0] exp_prg;
      logic [16:0] exp_chr;
      string       tag;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    n_vec = 0, n_bad = 0;
   bit    done = 0;

   logic [7:0] m_prev = '0;
   logic [2:0] m_prg = '0;
   logic [3:0] m_chr = '0;

   always @(mon_ev) begin
      while (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_vec++;
         if (prg_rom_addr !== it.exp_prg) begin
            n_bad++;
            $display("FAIL %s prg_rom_addr act=%h exp=%h", it.tag, prg_rom_addr, it.exp_prg);
         end
         n_vec++;
         if (chr_rom_addr !== it.exp_chr) begin
            n_bad++;
            $display("FAIL %s chr_rom_addr act=%h exp=%h", it.tag, chr_rom_addr, it.exp_chr);
         end
      end
   end

   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] rom);
      logic [7:0] eff;
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; prg_rom_rdata = rom; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0; prg_rom_rdata = 8'hFF;
      if (a[15] && rst_n) begin
         eff = d & rom;
         if (eff[7] && !m_prev[7]) m_prg = eff[2:0];
         if (eff[6] && !m_prev[6]) m_chr = eff[3:0];
         m_prev = eff;
      end
   endtask

   task automatic probe(input logic [15:0] a, input logic [12:0] p, input string tag);
      item_t it;
      @(negedge clk);
      cpu_addr = a; ppu_addr = p;
      #1;
      it.exp_prg = {(a[15:14] == 2'b11) ? 3'd7 : m_prg, a[13:0]};
      it.exp_chr = {m_chr, p};
      it.tag = tag;
      q.push_back(it);
      ->mon_ev;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      probe(16'h8123, 13'h0456, "R8 reset state");
      rst_n = 1'b1;
      probe(16'hC010, 13'h1FFF, "R3 upper window last bank");
      probe(16'hBFFF, 13'h0000, "R9 lower window bank 0");
      do_write(16'h8000, 8'h82, 8'hFF);
      probe(16'h8004, 13'h0010, "R4 rising load bank 2");
      probe(16'hFFFF, 13'h0011, "R3 upper window after load");
      do_write(16'h9000, 8'h83, 8'hFF);
      probe(16'h8004, 13'h0010, "R4 bit held high no reload");
      do_write(16'h8000, 8'h00, 8'hFF);
      do_write(16'hA000, 8'h85, 8'hFF);
      probe(16'hA5A5, 13'h0AAA, "R6 R4 clear then set reloads");
      do_write(16'h8000, 8'h43, 8'hFF);
      probe(16'h8001, 13'h1234, "R5 graphics load bank 3");
      do_write(16'h8000, 8'h00, 8'hFF);
      do_write(16'hE000, 8'hC9, 8'hFF);
      probe(16'h9ABC, 13'h0321, "R7 both banks same write");
      do_write(16'h7000, 8'h00, 8'hFF);
      do_write(16'h8000, 8'hC2, 8'hFF);
      probe(16'h8002, 13'h0002, "R1 low write ignored");
      do_write(16'h8000, 8'h00, 8'hFF);
      do_write(16'h8000, 8'h86, 8'h7F);
      probe(16'h8003, 13'h0003, "R2 ROM clears bit 7 blocks load");
      do_write(16'h8000, 8'h86, 8'hFF);
      probe(16'h8003, 13'h0003, "R2 later unmasked write loads");
      do_write(16'h8000, 8'h00, 8'hFF);
      do_write(16'h8000, 8'h8F, 8'hF3);
      probe(16'h8007, 13'h0007, "R2 data bits masked bank 3");
      do_write(16'h8000, 8'h00, 8'hFF);
      do_write(16'h8000, 8'h4F, 8'hF5);
      probe(16'h8008, 13'h1008, "R2 graphics data masked bank 5");
      do_write(16'h8000, 8'h00, 8'hFF);
      do_write(16'h8000, 8'hC4, 8'hBF);
      probe(16'h8009, 13'h0009, "R2 R5 bit 6 masked, program loads");
      @(negedge clk);
      rst_n = 1'b0;
      m_prev = '0; m_prg = '0; m_chr = '0;
      probe(16'hB000, 13'h1000, "R8 mid-run reset clears banks");
      rst_n = 1'b1;
      probe(16'hC000, 13'h0000, "R3 upper window after reset");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule